// File: doc/BRIEF.md
# Ethernet Pause Frame Generator

This block produces IEEE 802.3 MAC control pause frames on request from software. Three word-addressed registers set it up. A control register takes a request to resume (XON) or a request to stop (XOFF). A quanta register holds the pause time used by XOFF frames. An enable register gates all generation. When a valid request is present, the block sends one 60-byte frame, byte by byte, on a byte-wide stream with valid, start-of-packet, end-of-packet and ready. The request bit clears itself as soon as the frame begins.

Each frame contains, in order:

- the reserved multicast destination;
- a 48-bit source address taken from an input port;
- the MAC control type;
- the pause opcode;
- the pause time;
- zero padding up to 60 bytes.

The frame check sequence is added further down the transmit path. So is arbitration against client traffic.

Top module: `pause_frame_gen`

## Requirements
- R1: After reset the control register reads 0, the quanta register reads 0, the enable register reads 1, and `txValid` is low.
- R2: Writing 1 (bit 0 only) to the control register at address 0 sends one frame with pause time 0x0000. While that frame is being sent, the control register reads 0.
- R3: Writing 2 (bit 1 only) to the control register sends one frame whose pause time is the quanta register value.
- R4: If control bits 1:0 are both 1, no frame is sent and the control register keeps reading 3.
- R5: When bit 0 of the enable register (address 2) is 0, no frame is sent and a pending request stays readable in the control register. Setting enable back to 1 sends that frame.
- R6: The frame bytes are, in order:
  - bytes 0 to 5: 01 80 C2 00 00 01;
  - bytes 6 to 11: `srcMac`, bits 47:40 first;
  - bytes 12 to 13: 88 08;
  - bytes 14 to 15: 00 01;
  - bytes 16 to 17: pause time, most significant byte first;
  - bytes 18 to 59: zero.
- R7: A frame is exactly 60 accepted bytes. `txSop` is high only with byte 0 and `txEop` is high only with byte 59.
- R8: A byte is accepted only on a cycle where both `txValid` and `txReady` are high. While `txValid` is high and `txReady` is low, `txData`, `txSop` and `txEop` hold their values.
- R9: The quanta register at address 1 stores bits 15:0 of a write. Bits 31:16 always read as 0.
- R10: A control write that arrives while a frame is active is held back. It takes effect only after the frame ends, and then it starts its own frame.
- R11: Read data appears on the cycle after `regRdEn` is sampled. Any address other than 0, 1 or 2 reads as 0.
- R12: The pause time and source address are captured when a frame starts. Writing the quanta register during a frame does not change that frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regRdEn | input | 1 | Register read strobe |
| regAddr | input | 4 | Word address |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data, one cycle after `regRdEn` |
| srcMac | input | 48 | Source address placed in frames |
| txData | output | 8 | Stream byte |
| txValid | output | 1 | Stream byte valid |
| txSop | output | 1 | First byte of frame |
| txEop | output | 1 | Last byte of frame |
| txReady | input | 1 | Sink accepts byte |

## Verification
The main function is tried with an XON request, an XOFF request with a nonzero quanta, a request made while generation is disabled, and a request with both bits set. These separate a quanta taken from the register from one forced to zero, and a gated request from a discarded one.

Frames are driven both with `txReady` always high and with a pseudo-random stall pattern. This shows that bytes advance only on accepted cycles and stay stable while stalled.

A control write and a quanta write made in the middle of a frame show two things:
- the running frame keeps its captured pause time;
- the held request starts a second frame only after the first one ends.

// File: rtl/pause_gen_pkg.sv
package pause_gen_pkg;
  localparam int QUANTA_W  = 16;
  localparam int MAC_W     = 48;
  localparam int FRAME_LEN = 60;
  localparam int HDR_BYTES = 18;

  typedef struct packed {
    logic                start;
    logic [QUANTA_W-1:0] quanta;
    logic [MAC_W-1:0]    src;
  } launch_t;
endpackage

// File: rtl/pause_ctrl.sv
module pause_ctrl
  import pause_gen_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [MAC_W-1:0]  srcMac,
  input  logic              dpBusy,
  output launch_t           launch
);
  localparam logic [ADDR_W-1:0] ADDR_CTRL   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ADDR_QUANTA = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ADDR_ENABLE = ADDR_W'(2);

  logic [1:0]          ctrlReg;
  logic [QUANTA_W-1:0] quantaReg;
  logic                enReg;
  logic                pendValid;
  logic [1:0]          pendBits;

  logic reqXon, reqXoff, launchNow, ctrlWr, holdWr, applyPend;
  logic unusedWrBits;

  assign unusedWrBits = ^wrData[DATA_W-1:QUANTA_W];

  assign reqXon    = (ctrlReg == 2'b01);
  assign reqXoff   = (ctrlReg == 2'b10);
  assign launchNow = enReg && !dpBusy && !pendValid && (reqXon || reqXoff);
  assign ctrlWr    = wrEn && (addr == ADDR_CTRL);
  assign holdWr    = ctrlWr && (dpBusy || launchNow || pendValid);
  assign applyPend = pendValid && !dpBusy && !ctrlWr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctrlReg <= '0;
    end else if (launchNow) begin
      ctrlReg <= '0;
    end else if (applyPend) begin
      ctrlReg <= pendBits;
    end else if (ctrlWr && !holdWr) begin
      ctrlReg <= wrData[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendBits  <= '0;
    end else if (holdWr) begin
      pendValid <= 1'b1;
      pendBits  <= wrData[1:0];
    end else if (applyPend) begin
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      quantaReg <= '0;
      enReg     <= 1'b1;
    end else if (wrEn) begin
      if (addr == ADDR_QUANTA) quantaReg <= wrData[QUANTA_W-1:0];
      if (addr == ADDR_ENABLE) enReg     <= wrData[0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdData <= '0;
    end else if (rdEn) begin
      case (addr)
        ADDR_CTRL:   rdData <= {{(DATA_W-2){1'b0}}, ctrlReg};
        ADDR_QUANTA: rdData <= {{(DATA_W-QUANTA_W){1'b0}}, quantaReg};
        ADDR_ENABLE: rdData <= {{(DATA_W-1){1'b0}}, enReg};
        default:     rdData <= '0;
      endcase
    end
  end

  always_comb begin
    launch.start  = launchNow;
    launch.quanta = reqXoff ? quantaReg : '0;
    launch.src    = srcMac;
  end

  // R2: a launched request is gone from the control register next cycle
  a_r2_clear_on_start: assert property (@(posedge clk) disable iff (!rstN)
    launch.start |=> (ctrlReg == 2'b00));

  // R10: a control write during a frame is parked, not applied
  a_r10_hold_while_busy: assert property (@(posedge clk) disable iff (!rstN)
    (dpBusy && ctrlWr) |=> (pendValid && $stable(ctrlReg)));

  // R9: quanta reads never show the reserved upper bits
  a_r9_upper_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr == ADDR_QUANTA) |=> (rdData[DATA_W-1:QUANTA_W] == '0));

  // R11: unmapped reads return zero
  a_r11_unmapped_zero: assert property (@(posedge clk) disable iff (!rstN)
    (rdEn && addr > ADDR_ENABLE) |=> (rdData == '0));
endmodule

// File: rtl/pause_dp.sv
module pause_dp
  import pause_gen_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  launch_t    launch,
  input  logic       txReady,
  output logic [7:0] txData,
  output logic       txValid,
  output logic       txSop,
  output logic       txEop,
  output logic       busy
);
  localparam int IDX_W = $clog2(FRAME_LEN);
  localparam int HDR_W = HDR_BYTES * 8;
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_LEN - 1);
  localparam logic [IDX_W-1:0] HDR_END  = IDX_W'(HDR_BYTES);
  localparam logic [47:0] DEST_MAC  = 48'h0180_C200_0001;
  localparam logic [15:0] CTRL_TYPE = 16'h8808;
  localparam logic [15:0] PAUSE_OP  = 16'h0001;

  logic [IDX_W-1:0]    idx;
  logic [QUANTA_W-1:0] qLatch;
  logic [MAC_W-1:0]    srcLatch;
  logic                beat, lastByte;
  logic [HDR_W-1:0]    hdrAll, hdrShift;

  assign beat     = busy && txReady;
  assign lastByte = (idx == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy     <= 1'b0;
      idx      <= '0;
      qLatch   <= '0;
      srcLatch <= '0;
    end else if (launch.start) begin
      busy     <= 1'b1;
      idx      <= '0;
      qLatch   <= launch.quanta;
      srcLatch <= launch.src;
    end else if (beat) begin
      if (lastByte) busy <= 1'b0;
      else          idx  <= idx + IDX_W'(1);
    end
  end

  assign hdrAll   = {DEST_MAC, srcLatch, CTRL_TYPE, PAUSE_OP, qLatch};
  assign hdrShift = hdrAll << {idx, 3'b000};

  always_comb begin
    txValid = busy;
    txSop   = busy && (idx == '0);
    txEop   = busy && lastByte;
    txData  = (busy && idx < HDR_END) ? hdrShift[HDR_W-1 -: 8] : 8'h00;
  end

  // R8: stalled output holds its byte and markers
  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && !txReady) |=> (txValid && $stable(txData) && $stable(txSop) && $stable(txEop)));

  // R8: a new frame never starts over an active one
  a_r8_no_overlap: assert property (@(posedge clk) disable iff (!rstN)
    launch.start |-> !busy);

  // R7: start and end markers never coincide; stream idles after the end
  a_r7_markers_apart: assert property (@(posedge clk) disable iff (!rstN)
    txValid |-> !(txSop && txEop));
  a_r7_idle_after_end: assert property (@(posedge clk) disable iff (!rstN)
    (txValid && txEop && txReady) |=> !txValid);

  // R12: captured pause time is fixed for the frame
  a_r12_quanta_fixed: assert property (@(posedge clk) disable iff (!rstN)
    (busy && !launch.start) |=> $stable(qLatch));
endmodule

// File: rtl/pause_frame_gen.sv
module pause_frame_gen
  import pause_gen_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic              regRdEn,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [MAC_W-1:0]  srcMac,
  output logic [7:0]        txData,
  output logic              txValid,
  output logic              txSop,
  output logic              txEop,
  input  logic              txReady
);
  launch_t launch;
  logic    dpBusy;

  pause_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(regWrEn), .rdEn(regRdEn), .addr(regAddr),
    .wrData(regWrData), .rdData(regRdData), .srcMac(srcMac),
    .dpBusy(dpBusy), .launch(launch)
  );

  pause_dp u_dp (
    .clk(clk), .rstN(rstN), .launch(launch), .txReady(txReady),
    .txData(txData), .txValid(txValid), .txSop(txSop), .txEop(txEop),
    .busy(dpBusy)
  );
endmodule

// File: tb/pause_frame_gen_bench.sv
`timescale 1ns/1ps
module pause_frame_gen_bench;
  typedef struct packed {
    logic [7:0] d;
    logic       sop;
    logic       eop;
  } beat_t;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0, regRdEn = 1'b0;
  logic [3:0]  regAddr = '0;
  logic [31:0] regWrData = '0, regRdData;
  logic [47:0] srcMac = 48'h0211_2233_4455;
  logic [7:0]  txData;
  logic        txValid, txSop, txEop;
  logic        txReady = 1'b1;

  int    nChecks = 0, nFail = 0;
  beat_t expQ[$];
  bit    readyMode = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  bit    prevStall = 1'b0;
  logic [9:0] prevOut;

  always #2 clk = ~clk;

  pause_frame_gen u_pause_frame_gen (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regRdEn(regRdEn),
    .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .srcMac(srcMac), .txData(txData), .txValid(txValid), .txSop(txSop),
    .txEop(txEop), .txReady(txReady)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] refByte(input int i, input logic [15:0] q, input logic [47:0] src);
    logic [143:0] hdr;
    hdr = {48'h0180_C200_0001, src, 16'h8808, 16'h0001, q};
    if (i < 18) return hdr[143 - 8*i -: 8];
    return 8'h00;
  endfunction

  // driver: expected frame into the scoreboard (R6, R7)
  task automatic pushFrame(input logic [15:0] q, input logic [47:0] src);
    for (int i = 0; i < 60; i++) begin
      beat_t b;
      b.d   = refByte(i, q, src);
      b.sop = (i == 0);
      b.eop = (i == 59);
      expQ.push_back(b);
    end
  endtask

  task automatic regWrite(input logic [3:0] a, input logic [31:0] v);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = v;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [3:0] a, output logic [31:0] v);
    @(negedge clk);
    regRdEn = 1'b1; regAddr = a;
    @(negedge clk);
    regRdEn = 1'b0;
    v = regRdData;
  endtask

  task automatic waitIdle(input string tag);
    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      if (expQ.size() == 0 && !txValid) break;
    end
    chk(expQ.size() == 0 && !txValid, tag, 32'(expQ.size()), 32'd0);
  endtask

  // monitor: stall stability, then pop and compare accepted bytes
  always @(negedge clk) begin
    if (rstN) begin
      if (prevStall)
        chk(txValid && {txData, txSop, txEop} == prevOut, "R8 stalled output changed",
            32'({txValid, txData, txSop, txEop}), 32'({1'b1, prevOut}));
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      txReady = readyMode ? lfsr[0] : 1'b1;
      if (txValid && txReady) begin
        if (expQ.size() == 0) begin
          chk(1'b0, "R4/R5/R7 unexpected byte", 32'(txData), 32'hFFFF_FFFF);
        end else begin
          beat_t e;
          e = expQ.pop_front();
          chk(txData == e.d, "R6 frame byte", 32'(txData), 32'(e.d));
          chk({txSop, txEop} == {e.sop, e.eop}, "R7 sop/eop", 32'({txSop, txEop}), 32'({e.sop, e.eop}));
        end
      end
      prevStall = txValid && !txReady;
      prevOut   = {txData, txSop, txEop};
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    nFail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    chk(txValid == 1'b0, "R1 txValid after reset", 32'(txValid), 0);
    regRead(4'd0, v); chk(v == 0, "R1 control reset", v, 0);
    regRead(4'd1, v); chk(v == 0, "R1 quanta reset", v, 0);
    regRead(4'd2, v); chk(v == 1, "R1 enable reset", v, 1);
    // R11 unmapped addresses
    regRead(4'd7, v);  chk(v == 0, "R11 unmapped 7", v, 0);
    regRead(4'd15, v); chk(v == 0, "R11 unmapped 15", v, 0);

    // R9 quanta width
    regWrite(4'd1, 32'hDEAD_BEEF);
    regRead(4'd1, v); chk(v == 32'h0000_BEEF, "R9 quanta upper bits", v, 32'h0000_BEEF);

    // R2 XON, ready always high
    pushFrame(16'h0000, srcMac);
    regWrite(4'd0, 32'h1);
    waitIdle("R2 xon frame completes");
    regRead(4'd0, v); chk(v == 0, "R2 control cleared", v, 0);

    // R3 XOFF with random stalls
    readyMode = 1'b1;
    srcMac = 48'hA0B1_C2D3_E4F5;
    pushFrame(16'hBEEF, srcMac);
    regWrite(4'd0, 32'h2);
    waitIdle("R3 xoff frame completes");

    // R4 both bits set
    regWrite(4'd0, 32'h3);
    repeat (60) @(negedge clk);
    chk(txValid == 1'b0, "R4 no frame", 32'(txValid), 0);
    regRead(4'd0, v); chk(v == 3, "R4 control keeps 3", v, 3);
    regWrite(4'd0, 32'h0);

    // R5 enable gating
    regWrite(4'd2, 32'h0);
    regWrite(4'd0, 32'h2);
    repeat (60) @(negedge clk);
    chk(txValid == 1'b0, "R5 disabled no frame", 32'(txValid), 0);
    regRead(4'd0, v); chk(v == 2, "R5 request held", v, 2);
    regRead(4'd2, v); chk(v == 0, "R5 enable reads 0", v, 0);
    pushFrame(16'hBEEF, srcMac);
    regWrite(4'd2, 32'h1);
    waitIdle("R5 frame after enable");

    // R10 / R12 writes during an active frame
    regWrite(4'd1, 32'h0000_1234);
    pushFrame(16'h1234, srcMac);
    regWrite(4'd0, 32'h2);
    repeat (4) @(negedge clk);
    chk(txValid == 1'b1, "R10 frame active", 32'(txValid), 1);
    regRead(4'd0, v); chk(v == 0, "R2 control clears at frame start", v, 0);
    regWrite(4'd1, 32'h0000_5678);
    regWrite(4'd0, 32'h1);
    regRead(4'd0, v); chk(v == 0, "R10 write held during frame", v, 0);
    pushFrame(16'h0000, srcMac);
    waitIdle("R10 held request sends after frame");
    regRead(4'd0, v); chk(v == 0, "R10 control cleared after second frame", v, 0);
    regRead(4'd1, v); chk(v == 32'h5678, "R12 quanta write landed", v, 32'h5678);

    repeat (10) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
    $finish;
  end
endmodule